// File: doc/BRIEF.md
# Angle-to-ratiometric output mapper

This block turns an 8-bit absolute angle into the 10-bit code that drives a ratiometric analog output converter. First it corrects the angle for the counting direction and adds a programmable zero offset, with wrap at one full turn. It then takes one of four angular spans (a full turn, three quarters, one half or one quarter), clamps positions that fall outside that span and stretches the span over the converter range. The stretched value lands on either the whole supply range or a guarded window that covers 10% to 90% of the supply. In the guarded window a short to either rail shows up as an out-of-window voltage.

The code goes into a register on each clock. A second register carries the output-enable for the converter's tristate driver. That enable follows the device enable with the same one-cycle latency as the code, so an analog stage that is shared between several sensors sees a released output while this device is off.

Top module: `ratio_out_mapper`

## Requirements
- R1: In clockwise mode (mode bit 2 = 0) the position is p = (raw + offset) mod 256.
- R2: In counter-clockwise mode (mode bit 2 = 1) the raw angle is first replaced by (256 - raw) mod 256, so p = (offset - raw) mod 256.
- R3: Mode bits 1:0 select the span limit L: 00 gives 255 (full turn), 01 gives 192, 10 gives 128 and 11 gives 64. The scaled value is floor(min(p, L) * 1023 / L).
- R4: A position p greater than L clamps to L, so the scaled value is 1023.
- R5: With mode bit 3 = 0 (rail-to-rail window) the output code equals the scaled value, from 0 to 1023.
- R6: With mode bit 3 = 1 (guarded window) the output code is 102 + floor(scaled * 819 / 1023) and always lies in 102..921.
- R7: Position zero gives the window minimum (0 or 102). A position at or beyond the span limit gives the window maximum (1023 or 921).
- R8: The code and the output-enable are both registered. Each reflects the inputs of the previous clock edge. The output-enable is 0 in the cycle after enable_i was 0, and the code keeps updating while the output is disabled.
- R9: While rst_ni is low the code is 0 and the output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_angle_i | input | 8 | Measured absolute angle, 256 counts per turn |
| offset_i | input | 8 | Zero-position offset, added modulo 256 |
| mode_i | input | 4 | [3] guarded window, [2] counter-clockwise, [1:0] span select |
| enable_i | input | 1 | Device enable |
| dac_code_o | output | 10 | Registered converter code |
| dac_oe_o | output | 1 | Registered output-enable for the tristate driver |

## Verification
The bench builds the block with its default widths: an 8-bit angle and a 10-bit code. At these widths every raw angle can be swept under all sixteen mode codes, and the bench repeats that sweep for several offsets, including 0 and 255. The sweep therefore covers every clamp boundary, both window ends, the wrap in both directions and the rounding of each span divisor, and it compares each result with arithmetic worked out in the bench. Separate steps toggle the enable and apply reset during operation, to check that the output-enable releases and that the code clears.

// File: rtl/ratio_map_pkg.sv
package ratio_map_pkg;

  typedef enum logic [1:0] {
    SPAN_FULL = 2'b00,
    SPAN_3Q   = 2'b01,
    SPAN_HALF = 2'b10,
    SPAN_1Q   = 2'b11
  } span_e;

  typedef struct packed {
    logic  narrow;
    logic  ccw;
    span_e span;
  } map_mode_t;

  // span limit in angle counts; full turn tops out at the last code
  function automatic int span_limit(input int idx, input int ang_w);
    case (idx)
      0:       return (1 << ang_w) - 1;
      1:       return 3 * (1 << (ang_w - 2));
      2:       return 1 << (ang_w - 1);
      default: return 1 << (ang_w - 2);
    endcase
  endfunction

endpackage

// File: rtl/angle_adjust.sv
module angle_adjust #(
  parameter int ANG_W = 8
) (
  input  logic [ANG_W-1:0] raw_i,
  input  logic [ANG_W-1:0] offset_i,
  input  logic             ccw_i,
  output logic [ANG_W-1:0] pos_o
);

  logic [ANG_W-1:0] dir_ang;

  // negate modulo 2^ANG_W for reverse counting
  assign dir_ang = ccw_i ? (~raw_i + 1'b1) : raw_i;
  assign pos_o   = dir_ang + offset_i;

endmodule

// File: rtl/span_scaler.sv
module span_scaler
  import ratio_map_pkg::*;
#(
  parameter int ANG_W = 8,
  parameter int DAC_W = 10
) (
  input  logic [ANG_W-1:0] pos_i,
  input  span_e            span_i,
  output logic [DAC_W-1:0] scaled_o
);

  localparam int N_SPAN = 4;
  localparam int PW     = ANG_W + DAC_W;
  localparam int FS     = (1 << DAC_W) - 1;
  localparam logic [PW-1:0] FS_W = PW'(FS);

  logic [DAC_W-1:0] cand [N_SPAN];

  for (genvar g = 0; g < N_SPAN; g++) begin : g_span
    localparam int LIM = span_limit(g, ANG_W);
    localparam logic [PW-1:0] LIM_W = PW'(LIM);
    logic [PW-1:0] clamp_w;
    logic [PW-1:0] prod_w;
    assign clamp_w = (PW'(pos_i) > LIM_W) ? LIM_W : PW'(pos_i);
    assign prod_w  = clamp_w * FS_W;
    assign cand[g] = DAC_W'(prod_w / LIM_W);
  end

  assign scaled_o = cand[span_i];

endmodule

// File: rtl/window_map.sv
module window_map #(
  parameter int DAC_W = 10
) (
  input  logic [DAC_W-1:0] scaled_i,
  input  logic             narrow_i,
  output logic [DAC_W-1:0] code_o
);

  localparam int FS   = (1 << DAC_W) - 1;
  localparam int LO   = (FS + 5) / 10;
  localparam int HI   = (9 * FS + 5) / 10;
  localparam int SPAN = HI - LO;
  localparam int PW   = 2 * DAC_W;

  logic [PW-1:0] prod_w;
  logic [PW-1:0] guard_w;

  assign prod_w  = PW'(scaled_i) * PW'(SPAN);
  assign guard_w = PW'(LO) + prod_w / PW'(FS);
  assign code_o  = narrow_i ? DAC_W'(guard_w) : scaled_i;

endmodule

// File: rtl/ratio_out_mapper.sv
module ratio_out_mapper
  import ratio_map_pkg::*;
#(
  parameter int ANG_W = 8,
  parameter int DAC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ANG_W-1:0] raw_angle_i,
  input  logic [ANG_W-1:0] offset_i,
  input  logic [3:0]       mode_i,
  input  logic             enable_i,
  output logic [DAC_W-1:0] dac_code_o,
  output logic             dac_oe_o
);

  map_mode_t        mode;
  logic [ANG_W-1:0] pos;
  logic [DAC_W-1:0] scaled;
  logic [DAC_W-1:0] code_d;
  logic [DAC_W-1:0] code_q;
  logic             oe_q;

  assign mode = map_mode_t'(mode_i);

  angle_adjust #(.ANG_W(ANG_W)) i_adjust (
    .raw_i    (raw_angle_i),
    .offset_i (offset_i),
    .ccw_i    (mode.ccw),
    .pos_o    (pos)
  );

  span_scaler #(.ANG_W(ANG_W), .DAC_W(DAC_W)) i_scaler (
    .pos_i    (pos),
    .span_i   (mode.span),
    .scaled_o (scaled)
  );

  window_map #(.DAC_W(DAC_W)) i_window (
    .scaled_i (scaled),
    .narrow_i (mode.narrow),
    .code_o   (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      oe_q   <= enable_i;
    end
  end

  assign dac_code_o = code_q;
  assign dac_oe_o   = oe_q;

endmodule

// File: rtl/ratio_out_mapper_chk.sv
module ratio_out_mapper_chk #(
  parameter int ANG_W = 8,
  parameter int DAC_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ANG_W-1:0] raw_angle_i,
  input logic [ANG_W-1:0] offset_i,
  input logic [3:0]       mode_i,
  input logic             enable_i,
  input logic [DAC_W-1:0] dac_code_o,
  input logic             dac_oe_o
);

  localparam int FS = (1 << DAC_W) - 1;
  localparam logic [DAC_W-1:0] WIN_LO = DAC_W'((FS + 5) / 10);
  localparam logic [DAC_W-1:0] WIN_HI = DAC_W'((9 * FS + 5) / 10);
  localparam logic [ANG_W-1:0] QTR    = ANG_W'(1 << (ANG_W - 2));

  logic [ANG_W-1:0] pos_w;
  assign pos_w = mode_i[2] ? (offset_i - raw_angle_i) : (offset_i + raw_angle_i);

  p_oe_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> dac_oe_o);

  p_oe_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !dac_oe_o);

  p_narrow_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[3] |=> (dac_code_o >= WIN_LO) && (dac_code_o <= WIN_HI));

  p_zero_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_w == '0) |=> dac_code_o == ($past(mode_i[3]) ? WIN_LO : '0));

  p_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'b11 && pos_w >= QTR) |=>
      dac_code_o == ($past(mode_i[3]) ? WIN_HI : DAC_W'(FS)));

  p_full_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'b00 && pos_w == '1) |=>
      dac_code_o == ($past(mode_i[3]) ? WIN_HI : DAC_W'(FS)));

endmodule

bind ratio_out_mapper ratio_out_mapper_chk #(.ANG_W(ANG_W), .DAC_W(DAC_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .raw_angle_i (raw_angle_i),
  .offset_i    (offset_i),
  .mode_i      (mode_i),
  .enable_i    (enable_i),
  .dac_code_o  (dac_code_o),
  .dac_oe_o    (dac_oe_o)
);

// File: tb/test_ratio_out_mapper.sv
module test_ratio_out_mapper;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] raw_angle_i = '0;
  logic [7:0] offset_i = '0;
  logic [3:0] mode_i = '0;
  logic       enable_i = 1'b0;
  logic [9:0] dac_code_o;
  logic       dac_oe_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ratio_out_mapper i_ratio_out_mapper (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raw_angle_i (raw_angle_i),
    .offset_i    (offset_i),
    .mode_i      (mode_i),
    .enable_i    (enable_i),
    .dac_code_o  (dac_code_o),
    .dac_oe_o    (dac_oe_o)
  );

  function automatic int exp_pos(int raw, int off, int mode);
    if (mode[2]) return (off - raw + 256) % 256;
    return (raw + off) % 256;
  endfunction

  function automatic int exp_lim(int mode);
    case (mode & 3)
      0: return 255;
      1: return 192;
      2: return 128;
      default: return 64;
    endcase
  endfunction

  function automatic int exp_code(int raw, int off, int mode);
    int p = exp_pos(raw, off, mode);
    int l = exp_lim(mode);
    int sc;
    if (p > l) p = l;
    sc = p * 1023 / l;
    if (mode[3]) return 102 + sc * 819 / 1023;
    return sc;
  endfunction

  task automatic check(int act, int exp, string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (raw=%0d off=%0d mode=%0h)",
               tag, act, exp, raw_angle_i, offset_i, mode_i);
    end
  endtask

  task automatic apply(int raw, int off, int mode);
    raw_angle_i = 8'(raw);
    offset_i    = 8'(off);
    mode_i      = 4'(mode);
    @(negedge clk_i);
  endtask

  function automatic string tag_of(int raw, int off, int mode);
    if ((mode & 3) != 0 && exp_pos(raw, off, mode) > exp_lim(mode)) return "R4";
    if (mode[2]) return "R2";
    if (mode[3]) return "R6";
    if ((mode & 3) != 0) return "R3";
    return "R1 R5";
  endfunction

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int offs [5] = '{0, 1, 37, 200, 255};
    #30;
    check(dac_code_o, 0, "R9");
    check(dac_oe_o, 0, "R9");
    @(negedge clk_i);
    rst_ni = 1'b1;
    enable_i = 1'b1;
    @(negedge clk_i);
    check(dac_oe_o, 1, "R8");

    foreach (offs[k]) begin
      for (int m = 0; m < 16; m++) begin
        for (int r = 0; r < 256; r++) begin
          apply(r, offs[k], m);
          check(dac_code_o, exp_code(r, offs[k], m), tag_of(r, offs[k], m));
        end
      end
    end

    // window ends, R7
    apply(0, 0, 4'h0); check(dac_code_o, 0, "R7");
    apply(0, 0, 4'h8); check(dac_code_o, 102, "R7");
    apply(255, 0, 4'h0); check(dac_code_o, 1023, "R7");
    apply(255, 0, 4'h8); check(dac_code_o, 921, "R7");
    apply(100, 92, 4'h9); check(dac_code_o, 921, "R7");
    apply(10, 10, 4'hC); check(dac_code_o, 102, "R7");
    apply(64, 0, 4'h3); check(dac_code_o, 1023, "R4");
    apply(63, 0, 4'h3); check(dac_code_o, 1007, "R3");
    apply(1, 0, 4'h4); check(dac_code_o, 1023, "R2");

    // enable release with code still tracking, R8
    enable_i = 1'b0;
    apply(128, 0, 4'h2);
    check(dac_oe_o, 0, "R8");
    check(dac_code_o, 1023, "R8");
    apply(64, 0, 4'h2);
    check(dac_code_o, 511, "R8");
    enable_i = 1'b1;
    apply(64, 0, 4'h2);
    check(dac_oe_o, 1, "R8");

    // reset during operation, R9
    apply(200, 0, 4'h0);
    rst_ni = 1'b0;
    #1;
    check(dac_code_o, 0, "R9");
    check(dac_oe_o, 0, "R9");
    @(negedge clk_i);
    check(dac_code_o, 0, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule